// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the processor-facing side of a simple 8-data-bit, no-parity, one-stop-bit serial port. It decodes a small window of word-aligned registers, each carrying one byte in its low eight bits. The window holds four identification bytes, a data port, a combined status/control byte and a two-byte baud divisor. A single interrupt line combines the receive and transmit sources, and each source has its own enable bit.

Writing the data port loads a one-character transmit holding register, which is offered to an attached transmit shifter through a valid/ready handshake. Reading the data port returns the head of an attached receive FIFO and pops it. The receive FIFO reports its fill level, and the receiver reports framing and overrun events as one-cycle pulses. The divisor output drives the bit-rate generator. Its value is clock/(baud*4) - 1, and the reset default is computed from parameters.

Top module: `uart_regif`

## Requirements
- R1: After reset the status byte reads 0xA0 when the FIFO fill level is 0. At that point tx_valid_o and irq_o are 0 and baud_div_o equals CLK_HZ/(BAUD*4)-1, which is 107 with the default parameters.
- R2: Word indices 0..3 (byte offsets 0, 4, 8, 12) read bytes 0..3 of ID_WORD, least significant byte first. Writes to them have no effect.
- R3: The FIFO bits of the status byte follow the fill level. Bit 5 is set when the level is 0, bit 4 when it is RX_DEPTH-1, and bit 3 when it is RX_DEPTH.
- R4: A frame-error pulse sets status bit 0 and an overrun pulse sets bit 1. Both bits stay set until the status byte is written with that bit at 0. Writing a 1 keeps the bit. An event in the same cycle as a clearing write leaves the bit set.
- R5: A status write loads bit 2 (receive interrupt enable) and bit 6 (transmit interrupt enable). Bits 3, 4, 5 and 7 are read-only and ignore writes.
- R6: A data write (offset 16) while the transmit holder is empty drives the byte on tx_data_o and raises tx_valid_o from the next cycle. Status bit 7 reads 0 until the cycle after tx_valid_o and tx_ready_i are both high, when both return to idle.
- R7: A data write while the transmit holder is full is dropped, leaving tx_data_o and the status byte unchanged.
- R8: A data read returns rx_data_i. It pulses rx_pop_o in that cycle only when the fill level is nonzero.
- R9: irq_o is high when (bit 2 is set and the FIFO is non-empty or an error bit is set) or (bit 6 is set and bit 7 is set).
- R10: Offsets 24 and 28 hold the low and high bytes of baud_div_o. Each is writable and reads back its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits [4:2] select the word |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| tx_data_o | output | 8 | Character offered to the shifter |
| tx_valid_o | output | 1 | Transmit holder full |
| tx_ready_i | input | 1 | Shifter takes the character |
| rx_data_i | input | 8 | Receive FIFO head |
| rx_count_i | input | CNT_W | Receive FIFO fill level |
| rx_pop_o | output | 1 | Pop the receive FIFO |
| rx_ferr_i | input | 1 | Frame error event pulse |
| rx_oerr_i | input | 1 | Overrun event pulse |
| baud_div_o | output | DIV_W | Bit-rate divisor |
| irq_o | output | 1 | Combined interrupt |

## Verification
The register window is first walked with a table of reads and writes. That walk separates the identification constants, the divisor bytes and the writable and read-only status bits. Directed sequences then drive the transmit holder full and send a second write, which distinguishes a dropped write from an overwrite. The error pulses are timed against status writes so that set-wins behaviour is distinguished from clear-wins behaviour. Fill levels 0, 2, RX_DEPTH-1 and RX_DEPTH are presented to tell apart the three FIFO flags. Each interrupt source is toggled on its own, so a wrong gating term shows up on irq_o.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  typedef enum logic [2:0] {
    W_ID0 = 3'd0, W_ID1 = 3'd1, W_ID2 = 3'd2, W_ID3 = 3'd3,
    W_DATA = 3'd4, W_STAT = 3'd5, W_BAUDL = 3'd6, W_BAUDH = 3'd7
  } word_e;

  // status byte bit positions (software-visible)
  localparam int unsigned SB_FERR  = 0;
  localparam int unsigned SB_OERR  = 1;
  localparam int unsigned SB_RXIE  = 2;
  localparam int unsigned SB_RXFUL = 3;
  localparam int unsigned SB_RXONE = 4;
  localparam int unsigned SB_RXEMP = 5;
  localparam int unsigned SB_TXIE  = 6;
  localparam int unsigned SB_TXEMP = 7;
endpackage

// File: rtl/uart_regif_status.sv
module uart_regif_status
  import uart_regif_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       ferr_evt_i,
  input  logic       oerr_evt_i,
  output logic       ferr_o,
  output logic       oerr_o,
  output logic       rx_ie_o,
  output logic       tx_ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ferr_o  <= 1'b0;
      oerr_o  <= 1'b0;
      rx_ie_o <= 1'b0;
      tx_ie_o <= 1'b0;
    end else if (wr_en_i) begin
      rx_ie_o <= wdata_i[SB_RXIE];
      tx_ie_o <= wdata_i[SB_TXIE];
      // write-zero clears; a new event wins over the clear
      ferr_o  <= ferr_evt_i | (ferr_o & wdata_i[SB_FERR]);
      oerr_o  <= oerr_evt_i | (oerr_o & wdata_i[SB_OERR]);
    end else begin
      ferr_o  <= ferr_o | ferr_evt_i;
      oerr_o  <= oerr_o | oerr_evt_i;
    end
  end

  a_r4_ferr_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_evt_i |=> ferr_o);
  a_r4_oerr_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_evt_i |=> oerr_o);
  a_r4_ferr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !ferr_evt_i) |=> $stable(ferr_o));
  a_r5_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rx_ie_o == $past(wdata_i[SB_RXIE])) && (tx_ie_o == $past(wdata_i[SB_TXIE])));
endmodule

// File: rtl/uart_regif_txhold.sv
module uart_regif_txhold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end else if (load_i && !valid_o) begin
      data_o  <= data_i;
      valid_o <= 1'b1;
    end
  end

  a_r6_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> !valid_o);
  a_r7_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && load_i) |=> $stable(data_o));
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && load_i) |=> (valid_o && data_o == $past(data_i)));
endmodule

// File: rtl/uart_regif_baud.sv
module uart_regif_baud #(
  parameter int unsigned           DIV_W   = 16,
  parameter logic [DIV_W-1:0]      DEF_DIV = '0,
  localparam int unsigned          NB      = DIV_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    wr_en_i,
  input  logic [7:0]       wdata_i,
  output logic [DIV_W-1:0] div_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         div_o[b*8 +: 8] <= DEF_DIV[b*8 +: 8];
      else if (wr_en_i[b]) div_o[b*8 +: 8] <= wdata_i;
    end

    a_r10_byte_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[b] |=> div_o[b*8 +: 8] == $past(wdata_i));
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned  ADDR_W   = 5,
  parameter int unsigned  RX_DEPTH = 4,
  parameter int unsigned  DIV_W    = 16,
  parameter int unsigned  CLK_HZ   = 50_000_000,
  parameter int unsigned  BAUD     = 115_200,
  parameter logic [31:0]  ID_WORD  = 32'h4A17_C35E,
  localparam int unsigned CNT_W    = $clog2(RX_DEPTH + 1),
  localparam logic [DIV_W-1:0] DEF_DIV = DIV_W'(CLK_HZ / (BAUD * 4) - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_data_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  output logic              rx_pop_o,
  input  logic              rx_ferr_i,
  input  logic              rx_oerr_i,
  output logic [DIV_W-1:0]  baud_div_o,
  output logic              irq_o
);
  localparam int unsigned NB = DIV_W / 8;

  word_e idx;
  logic  wr_acc, rd_acc;
  logic  ferr, oerr, rx_ie, tx_ie;
  logic  rx_empty, rx_full, rx_one, tx_empty;
  logic  [7:0] status;
  logic  [NB-1:0] baud_we;

  assign idx    = word_e'(addr_i[4:2]);
  assign wr_acc = sel_i & wr_i;
  assign rd_acc = sel_i & ~wr_i;

  assign rx_empty = (rx_count_i == '0);
  assign rx_full  = (rx_count_i == CNT_W'(RX_DEPTH));
  assign rx_one   = (rx_count_i == CNT_W'(RX_DEPTH - 1));
  assign tx_empty = ~tx_valid_o;

  uart_regif_status i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_acc && idx == W_STAT),
    .wdata_i    (wdata_i),
    .ferr_evt_i (rx_ferr_i),
    .oerr_evt_i (rx_oerr_i),
    .ferr_o     (ferr),
    .oerr_o     (oerr),
    .rx_ie_o    (rx_ie),
    .tx_ie_o    (tx_ie)
  );

  uart_regif_txhold #(.DW(8)) i_txhold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr_acc && idx == W_DATA),
    .data_i  (wdata_i),
    .ready_i (tx_ready_i),
    .data_o  (tx_data_o),
    .valid_o (tx_valid_o)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bwe
    assign baud_we[b] = wr_acc && (addr_i[4:2] == 3'(W_BAUDL + b));
  end

  uart_regif_baud #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) i_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (baud_we),
    .wdata_i (wdata_i),
    .div_o   (baud_div_o)
  );

  always_comb begin
    status           = '0;
    status[SB_FERR]  = ferr;
    status[SB_OERR]  = oerr;
    status[SB_RXIE]  = rx_ie;
    status[SB_RXFUL] = rx_full;
    status[SB_RXONE] = rx_one;
    status[SB_RXEMP] = rx_empty;
    status[SB_TXIE]  = tx_ie;
    status[SB_TXEMP] = tx_empty;
  end

  always_comb begin
    unique case (idx)
      W_ID0, W_ID1, W_ID2, W_ID3: rdata_o = ID_WORD[addr_i[3:2]*8 +: 8];
      W_DATA:  rdata_o = rx_data_i;
      W_STAT:  rdata_o = status;
      W_BAUDL: rdata_o = baud_div_o[7:0];
      W_BAUDH: rdata_o = baud_div_o[15:8];
      default: rdata_o = '0;
    endcase
  end

  assign rx_pop_o = rd_acc && idx == W_DATA && !rx_empty;
  assign irq_o    = (rx_ie && (!rx_empty || ferr || oerr)) || (tx_ie && tx_empty);

  a_r8_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (rx_count_i != '0 && sel_i && !wr_i));
  a_r9_rx_err_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ie && (ferr || oerr)) |-> irq_o);
  a_r9_tx_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ie && !tx_valid_o) |-> irq_o);
endmodule

// File: tb/test_uart_regif.sv
module test_uart_regif;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 18;
  // {wr, addr[4:0], wdata, expected read}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'd0,  8'h00, 8'h5E}, {1'b0, 5'd4,  8'h00, 8'hC3},
    {1'b0, 5'd8,  8'h00, 8'h17}, {1'b0, 5'd12, 8'h00, 8'h4A},
    {1'b1, 5'd0,  8'hFF, 8'h00}, {1'b0, 5'd0,  8'h00, 8'h5E},
    {1'b0, 5'd24, 8'h00, 8'h6B}, {1'b0, 5'd28, 8'h00, 8'h00},
    {1'b1, 5'd24, 8'h34, 8'h00}, {1'b1, 5'd28, 8'h12, 8'h00},
    {1'b0, 5'd24, 8'h00, 8'h34}, {1'b0, 5'd28, 8'h00, 8'h12},
    {1'b1, 5'd20, 8'hBF, 8'h00}, {1'b0, 5'd20, 8'h00, 8'hA4},
    {1'b1, 5'd20, 8'h40, 8'h00}, {1'b0, 5'd20, 8'h00, 8'hE0},
    {1'b1, 5'd20, 8'h00, 8'h00}, {1'b0, 5'd20, 8'h00, 8'hA0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata, tx_data, rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0, rx_pop, ferr = 1'b0, oerr = 1'b0, irq;
  logic [2:0]  rx_count = '0;
  logic [15:0] baud_div;
  logic [7:0]  rd_q;
  logic        pop_q;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif i_uart_regif (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .rx_data_i(rx_data), .rx_count_i(rx_count),
    .rx_pop_o(rx_pop), .rx_ferr_i(ferr), .rx_oerr_i(oerr),
    .baud_div_o(baud_div), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    #1 rd_q = rdata; pop_q = rx_pop;
    @(posedge clk);
    #1 sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_stat(input string req, input logic [7:0] exp);
    bus(1'b0, 5'd20, 8'h00);
    chk(req, 32'(rd_q), 32'(exp));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 baud", 32'(baud_div), 32'd107);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    rd_stat("R1 status", 8'hA0);

    // table: R2 id, R10 divisor, R5 enable/read-only bits
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][21], VEC[i][20:16], VEC[i][15:8]);
      if (!VEC[i][21])
        chk(VEC[i][20:16] < 5'd16 ? "R2 id" : (VEC[i][20:16] == 5'd20 ? "R5 status" : "R10 baud"),
            32'(rd_q), 32'(VEC[i][7:0]));
    end
    chk("R10 div out", 32'(baud_div), 32'h1234);

    // R6 load, R7 drop
    bus(1'b1, 5'd16, 8'h55);
    chk("R6 valid", 32'(tx_valid), 1);
    chk("R6 data", 32'(tx_data), 32'h55);
    rd_stat("R6 busy", 8'h20);
    bus(1'b1, 5'd16, 8'hAA);
    chk("R7 data kept", 32'(tx_data), 32'h55);
    rd_stat("R7 status kept", 8'h20);
    @(negedge clk) tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    chk("R6 taken", 32'(tx_valid), 0);
    rd_stat("R6 empty again", 8'hA0);

    // R9 transmit source
    bus(1'b1, 5'd20, 8'h40);
    #1 chk("R9 tx irq on", 32'(irq), 1);
    bus(1'b1, 5'd16, 8'h77);
    #1 chk("R9 tx irq busy", 32'(irq), 0);
    @(negedge clk) tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    chk("R9 tx irq after take", 32'(irq), 1);
    bus(1'b1, 5'd20, 8'h00);
    #1 chk("R9 tx irq off", 32'(irq), 0);

    // R9 receive source, R3 level flags, R8 pop
    bus(1'b1, 5'd20, 8'h04);
    #1 chk("R9 rx empty no irq", 32'(irq), 0);
    rx_count = 3'd2; rx_data = 8'h3C;
    #1 chk("R9 rx data irq", 32'(irq), 1);
    rd_stat("R3 level2", 8'h84);
    rx_count = 3'd3;
    rd_stat("R3 one room", 8'h94);
    rx_count = 3'd4;
    rd_stat("R3 full", 8'h8C);
    bus(1'b0, 5'd16, 8'h00);
    chk("R8 data", 32'(rd_q), 32'h3C);
    chk("R8 pop", 32'(pop_q), 1);
    rx_count = 3'd0;
    bus(1'b0, 5'd16, 8'h00);
    chk("R8 no pop empty", 32'(pop_q), 0);

    // R4 sticky errors
    @(negedge clk) ferr = 1'b1;
    @(posedge clk); #1 ferr = 1'b0;
    rd_stat("R4 ferr set", 8'hA5);
    chk("R9 err irq", 32'(irq), 1);
    bus(1'b1, 5'd20, 8'h05);
    rd_stat("R4 write one keeps", 8'hA5);
    bus(1'b1, 5'd20, 8'h04);
    rd_stat("R4 write zero clears", 8'hA4);
    chk("R9 irq after clear", 32'(irq), 0);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 5'd20; wdata = 8'h04; oerr = 1'b1;
    @(posedge clk); #1 sel = 1'b0; wr = 1'b0; oerr = 1'b0;
    rd_stat("R4 set wins", 8'hA6);
    bus(1'b1, 5'd20, 8'h04);
    rd_stat("R4 oerr cleared", 8'hA4);

    finish_run();
  end
endmodule